// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block sits between the PWM modulator of a synchronous step-down converter and the two gate drivers. It turns the raw PWM request into two gate commands, one for the high-side switch and one for the low-side switch. Each command follows the PWM phase. The two commands never overlap.

Neither switch is turned on after a fixed delay. Each turn-on waits until the other gate is sensed off, and until a minimum both-off gap, counted in fast-clock cycles, has passed. The low-side turn-on also waits until a comparator reports that the switch node has fallen below its threshold. If that indication does not arrive within a timeout, the low side is skipped for the rest of the period.

A shutdown input or an error-amplifier-below-threshold input forces both gates off. After either is released, switching resumes only at the next PWM rising edge. The high-side on time is capped at a fixed fraction of the nominal switching period.

All six inputs pass through a synchronizer of `SYNC_STAGES` flops, with a default of 2. The default timing uses a 100 MHz clock: a 5-cycle minimum gap, a 50-cycle switch-node timeout, a 333-cycle nominal period and a 94 % duty cap, which gives 313 cycles.

The controller has six states:
- `GS_HALT`: forced off. It is the reset state.
- `GS_PARK`: both gates off, waiting for a new period.
- `GS_GAP_LH`: the gap from low-side off to high-side on.
- `GS_HIGH`: the high side is on.
- `GS_GAP_HL`: the gap from high-side off to low-side on.
- `GS_LOW`: the low side is on.

The transitions are:
- Any state goes to `GS_HALT` when a halt input is active. `GS_HALT` goes to `GS_PARK` once both halt inputs are clear.
- `GS_PARK` and `GS_LOW` go to `GS_GAP_LH` on a PWM rise.
- `GS_GAP_LH` goes to `GS_HIGH` when the gap is done and the low gate is sensed off. It goes to `GS_GAP_HL` if PWM falls first.
- `GS_HIGH` goes to `GS_GAP_HL` when PWM falls or the duty cap is reached.
- `GS_GAP_HL` goes to `GS_GAP_LH` on a PWM rise. It goes to `GS_LOW` when the gap is done, the high gate is sensed off and the switch node is low. It goes to `GS_PARK` when the timeout expires.

Top module: `gate_deadtime_ctrl`

## Requirements
- R1: While reset is held, and after it is released until the first synchronized PWM rising edge, both `hs_drv` and `ls_drv` are 0.
- R2: `hs_drv` and `ls_drv` are never 1 in the same clock cycle.
- R3: `hs_drv` rises only after a new PWM period has begun (a synchronized PWM rising edge), with `ls_gate_low` sensed 1 and `ls_drv` low for at least `DEAD_CYC` consecutive cycles.
- R4: `ls_drv` rises only after `hs_gate_low` and `sw_node_low` are both sensed 1, with `hs_drv` low for at least `DEAD_CYC` consecutive cycles.
- R5: If the low-side turn-on conditions are not met within `SW_TMO_CYC` cycles of high-side turn-off, `ls_drv` stays 0 until the next PWM rising edge.
- R6: `hs_drv` stays high for at most `PERIOD_CYC*DUTY_PCT/100` consecutive cycles. After the cap it stays low for the rest of the period, and the low side follows the R4 rules.
- R7: A 1 on `shutdown` drives both outputs to 0 from the `SYNC_STAGES+1`-th clock edge after it is applied. They stay 0 while it is held, and after release until the next PWM rising edge.
- R8: A 1 on `comp_low` has the same effect as `shutdown` in R7.
- R9: A PWM fall ends the high-side pulse: `hs_drv` goes to 0 at the `SYNC_STAGES+1`-th clock edge after PWM goes low, and not before.
- R10: `ls_drv` stays on through the PWM-low phase until the next PWM rise. A PWM pulse that ends before the low-to-high gap completes produces no high-side pulse, and the low side turns back on.
- R11: On every clock the outputs match the state sequence defined by R3 to R10, applied to the inputs as delayed by `SYNC_STAGES` flops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sequencing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_req | input | 1 | Raw PWM request; 1 asks for the high-side phase |
| sw_node_low | input | 1 | 1 when the switch node is below the low threshold |
| hs_gate_low | input | 1 | 1 when the high-side gate is sensed off |
| ls_gate_low | input | 1 | 1 when the low-side gate is sensed off |
| shutdown | input | 1 | Shutdown or fault request, active high |
| comp_low | input | 1 | 1 when the error-amplifier output is below its shutdown threshold |
| hs_drv | output | 1 | High-side gate command |
| ls_drv | output | 1 | Low-side gate command |

## Verification
The hardest situations to reach are:
- the switch-node timeout, where the high side has turned off but the switch node never reports low;
- the duty cap, where PWM stays high longer than the cap allows.

The bench closes the loop around the block. It echoes the gate commands back as delayed gate-sense and switch-node bits. It can pin the switch-node bit inactive to force the timeout into `GS_PARK`, and it can stretch the PWM pulse well past the cap. A two-cycle PWM pulse covers the gap-abort path. Halts are applied during both the high phase and the low phase.

// File: rtl/gdt_pkg.sv
`timescale 1ns/1ps
package gdt_pkg;

    typedef enum logic [2:0] {
        GS_HALT   = 3'd0,
        GS_PARK   = 3'd1,
        GS_GAP_LH = 3'd2,
        GS_HIGH   = 3'd3,
        GS_GAP_HL = 3'd4,
        GS_LOW    = 3'd5
    } gdt_state_e;

    // Synchronized input bundle; bit 0 is the PWM request.
    typedef struct packed {
        logic comp_low;
        logic shutdown;
        logic ls_gl;
        logic hs_gl;
        logic sw_low;
        logic pwm;
    } gdt_in_s;

endpackage

// File: rtl/gdt_sync.sv
`timescale 1ns/1ps
module gdt_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [W-1:0] stg [STAGES];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) begin
                        stg[i] <= '0;
                    end
                end else begin
                    stg[0] <= d;
                    for (int i = 1; i < STAGES; i++) begin
                        stg[i] <= stg[i-1];
                    end
                end
            end

            assign q = stg[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/gdt_timer.sv
`timescale 1ns/1ps
module gdt_timer #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    output logic [CW-1:0] cnt
);

    // Cycles spent in the current state; saturates at all ones.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/gdt_fsm.sv
`timescale 1ns/1ps
module gdt_fsm
    import gdt_pkg::*;
#(
    parameter int CW         = 9,
    parameter int DEAD_CYC   = 5,
    parameter int SW_TMO_CYC = 50,
    parameter int MAX_ON     = 313
) (
    input  logic          clk,
    input  logic          rst_n,
    input  gdt_in_s       sig,
    input  logic [CW-1:0] cnt,
    output logic          clear,
    output logic          hs_drv,
    output logic          ls_drv
);

    localparam logic [CW-1:0] GAP_LAST = CW'(DEAD_CYC - 1);
    localparam logic [CW-1:0] TMO_LAST = CW'(SW_TMO_CYC - 1);
    localparam logic [CW-1:0] ON_LAST  = CW'(MAX_ON - 1);

    gdt_state_e st;
    gdt_state_e nxt;
    logic       pwm_prev;
    logic       halt;
    logic       rise;
    logic       gap_done;

    assign halt     = sig.shutdown | sig.comp_low;
    assign rise     = sig.pwm & ~pwm_prev;
    assign gap_done = (cnt >= GAP_LAST);
    assign clear    = (nxt != st);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwm_prev <= 1'b0;
        end else begin
            pwm_prev <= sig.pwm;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= GS_HALT;
        end else begin
            st <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = st;
        if (halt) begin
            nxt = GS_HALT;
        end else begin
            unique case (st)
                GS_HALT: begin
                    nxt = GS_PARK;
                end
                GS_PARK: begin
                    if (rise) nxt = GS_GAP_LH;
                end
                GS_GAP_LH: begin
                    if (!sig.pwm) begin
                        nxt = GS_GAP_HL;
                    end else if (sig.ls_gl && gap_done) begin
                        nxt = GS_HIGH;
                    end
                end
                GS_HIGH: begin
                    if (!sig.pwm || (cnt >= ON_LAST)) nxt = GS_GAP_HL;
                end
                GS_GAP_HL: begin
                    if (rise) begin
                        nxt = GS_GAP_LH;
                    end else if (sig.hs_gl && sig.sw_low && gap_done) begin
                        nxt = GS_LOW;
                    end else if (cnt >= TMO_LAST) begin
                        nxt = GS_PARK;
                    end
                end
                GS_LOW: begin
                    if (rise) nxt = GS_GAP_LH;
                end
                default: nxt = GS_HALT;
            endcase
        end
    end

    // Output decode
    always_comb begin
        hs_drv = 1'b0;
        ls_drv = 1'b0;
        unique case (st)
            GS_HIGH: hs_drv = 1'b1;
            GS_LOW:  ls_drv = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/gate_deadtime_ctrl.sv
`timescale 1ns/1ps
module gate_deadtime_ctrl
    import gdt_pkg::*;
#(
    parameter int DEAD_CYC    = 5,
    parameter int SW_TMO_CYC  = 50,
    parameter int PERIOD_CYC  = 333,
    parameter int DUTY_PCT    = 94,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_req,
    input  logic sw_node_low,
    input  logic hs_gate_low,
    input  logic ls_gate_low,
    input  logic shutdown,
    input  logic comp_low,
    output logic hs_drv,
    output logic ls_drv
);

    localparam int MAX_ON = (PERIOD_CYC * DUTY_PCT) / 100;
    localparam int CNT_W  = $clog2(MAX_ON + SW_TMO_CYC + DEAD_CYC + 2);
    localparam int IN_W   = $bits(gdt_in_s);

    logic [IN_W-1:0]  raw_bits;
    logic [IN_W-1:0]  syn_bits;
    gdt_in_s          syn;
    logic [CNT_W-1:0] cnt;
    logic             clear;

    assign raw_bits = {comp_low, shutdown, ls_gate_low, hs_gate_low, sw_node_low, pwm_req};
    assign syn      = gdt_in_s'(syn_bits);

    gdt_sync #(
        .W      (IN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_bits),
        .q     (syn_bits)
    );

    gdt_timer #(
        .CW (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .cnt   (cnt)
    );

    gdt_fsm #(
        .CW         (CNT_W),
        .DEAD_CYC   (DEAD_CYC),
        .SW_TMO_CYC (SW_TMO_CYC),
        .MAX_ON     (MAX_ON)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig    (syn),
        .cnt    (cnt),
        .clear  (clear),
        .hs_drv (hs_drv),
        .ls_drv (ls_drv)
    );

endmodule

// File: rtl/gdt_checker.sv
`timescale 1ns/1ps
module gdt_checker #(
    parameter int DEAD_CYC = 5,
    parameter int MAX_ON   = 313
) (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_drv,
    input logic       ls_drv,
    input logic [5:0] syn
);

    localparam int SAT = 1000000;

    int hs_off_run;
    int ls_off_run;
    int hs_on_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_off_run <= 0;
            ls_off_run <= 0;
            hs_on_run  <= 0;
        end else begin
            hs_off_run <= hs_drv ? 0 : ((hs_off_run < SAT) ? hs_off_run + 1 : hs_off_run);
            ls_off_run <= ls_drv ? 0 : ((ls_off_run < SAT) ? ls_off_run + 1 : ls_off_run);
            hs_on_run  <= hs_drv ? ((hs_on_run < SAT) ? hs_on_run + 1 : hs_on_run) : 0;
        end
    end

    AST_HS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_drv) |-> (ls_off_run >= DEAD_CYC)); // R3

    AST_HS_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_drv) |-> ($past(syn[0]) && $past(syn[3]))); // R3

    AST_LS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_drv) |-> (hs_off_run >= DEAD_CYC)); // R4

    AST_LS_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_drv) |-> ($past(syn[1]) && $past(syn[2]))); // R4

    AST_DUTY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        hs_drv |-> (hs_on_run < MAX_ON)); // R6

    AST_SHUTDOWN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        syn[4] |=> (!hs_drv && !ls_drv)); // R7

    AST_COMP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        syn[5] |=> (!hs_drv && !ls_drv)); // R8

endmodule

bind gate_deadtime_ctrl gdt_checker #(
    .DEAD_CYC (DEAD_CYC),
    .MAX_ON   (MAX_ON)
) u_gdt_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .hs_drv (hs_drv),
    .ls_drv (ls_drv),
    .syn    (syn_bits)
);

// File: tb/gate_deadtime_ctrl_test.sv
`timescale 1ns/1ps
module gate_deadtime_ctrl_test;

    localparam int DEAD  = 5;
    localparam int TMO   = 50;
    localparam int PER   = 333;
    localparam int DUTY  = 94;
    localparam int SYNC  = 2;
    localparam int MAXON = PER * DUTY / 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm = 1'b0;
    logic sw_low = 1'b1;
    logic hgl = 1'b1;
    logic lgl = 1'b1;
    logic sd = 1'b0;
    logic cl = 1'b0;
    logic hs;
    logic ls;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // feedback settings
    bit sw_stuck = 1'b0;
    int gl_dly = 1;
    int sw_dly = 3;
    logic [31:0] hist_h = '0;
    logic [31:0] hist_l = '0;

    // monitors
    int hs_low_run = 0;
    int ls_low_run = 0;
    int hs_run = 0;
    int last_hs_run = 0;
    bit hs_seen = 1'b0;
    bit ls_seen = 1'b0;
    bit ls_rise_pwm = 1'b0;
    logic hs_d = 1'b0;
    logic ls_d = 1'b0;

    // reference model
    logic [5:0] q[$];
    int m_ph = 0;
    int m_cnt = 0;

    always #2.5 clk = ~clk;

    gate_deadtime_ctrl #(
        .DEAD_CYC    (DEAD),
        .SW_TMO_CYC  (TMO),
        .PERIOD_CYC  (PER),
        .DUTY_PCT    (DUTY),
        .SYNC_STAGES (SYNC)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwm_req     (pwm),
        .sw_node_low (sw_low),
        .hs_gate_low (hgl),
        .ls_gate_low (lgl),
        .shutdown    (sd),
        .comp_low    (cl),
        .hs_drv      (hs),
        .ls_drv      (ls)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic period(input int h, input int l);
        pwm = 1'b1;
        step(h);
        pwm = 1'b0;
        step(l);
    endtask

    // Phases: 0 halted, 1 parked, 2 gap to high, 3 high, 4 gap to low, 5 low
    always @(posedge clk) begin : ref_model
        logic [5:0] s;
        logic [5:0] p;
        int nph;
        bit halt;
        bit rise;
        if (!rst_n) begin
            q.delete();
            for (int i = 0; i < SYNC + 2; i++) q.push_back(6'd0);
            m_ph = 0;
            m_cnt = 0;
        end else begin
            q.push_front({cl, sd, lgl, hgl, sw_low, pwm});
            s = q[SYNC];
            p = q[SYNC + 1];
            q = q[0:SYNC + 1];
            halt = s[5] | s[4];
            rise = s[0] & ~p[0];
            nph = m_ph;
            if (halt) nph = 0;
            else if (m_ph == 0) nph = 1;
            else if (m_ph == 1) begin
                if (rise) nph = 2;
            end else if (m_ph == 2) begin
                if (!s[0]) nph = 4;
                else if (s[3] && m_cnt >= DEAD - 1) nph = 3;
            end else if (m_ph == 3) begin
                if (!s[0] || m_cnt >= MAXON - 1) nph = 4;
            end else if (m_ph == 4) begin
                if (rise) nph = 2;
                else if (s[2] && s[1] && m_cnt >= DEAD - 1) nph = 5;
                else if (m_cnt >= TMO - 1) nph = 1;
            end else begin
                if (rise) nph = 2;
            end
            m_cnt = (nph != m_ph) ? 0 : m_cnt + 1;
            m_ph = nph;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            // R11 cycle-exact comparison with the reference
            chk((hs === (m_ph == 3)) && (ls === (m_ph == 5)), "R11 outputs vs reference",
                {30'd0, hs, ls}, {30'd0, (m_ph == 3), (m_ph == 5)});
            // R2 no overlap
            chk(!(hs && ls), "R2 both drives high", {30'd0, hs, ls}, 0);
            if (hs && !hs_d) chk(ls_low_run >= DEAD, "R3 gap before high-side on", ls_low_run, DEAD);
            if (ls && !ls_d) begin
                chk(hs_low_run >= DEAD, "R4 gap before low-side on", hs_low_run, DEAD);
                chk(!sw_stuck, "R5 low-side on while switch node never low", 1, 0);
                if (pwm) ls_rise_pwm = 1'b1;
            end
            if (!hs && hs_d) last_hs_run = hs_run;
            hs_run     = hs ? hs_run + 1 : 0;
            hs_low_run = hs ? 0 : hs_low_run + 1;
            ls_low_run = ls ? 0 : ls_low_run + 1;
            if (hs) hs_seen = 1'b1;
            if (ls) ls_seen = 1'b1;
            hs_d = hs;
            ls_d = ls;
        end
        hist_h = {hist_h[30:0], hs};
        hist_l = {hist_l[30:0], ls};
        hgl    = ~hist_h[gl_dly];
        lgl    = ~hist_l[gl_dly];
        sw_low = ~sw_stuck & ~hist_h[sw_dly];
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 reset
        step(5);
        chk(!hs && !ls, "R1 drives low in reset", {30'd0, hs, ls}, 0);
        rst_n = 1'b1;
        step(20);
        chk(!hs && !ls, "R1 drives low before first PWM edge", {30'd0, hs, ls}, 0);

        // Normal periods
        period(120, 213);
        period(120, 213);
        pwm = 1'b1;
        step(100);
        chk(hs === 1'b1, "R3 high side on during PWM high", hs, 1);
        pwm = 1'b0;
        step(SYNC);
        chk(hs === 1'b1, "R9 high side held until latency", hs, 1);
        step(1);
        chk(hs === 1'b0, "R9 high side off after PWM fall", hs, 0);
        step(200);
        chk(ls === 1'b1, "R10 low side on through PWM low", ls, 1);
        chk(ls_seen, "R4 low side turned on", ls_seen, 1);

        // Switch node never low
        sw_stuck = 1'b1;
        pwm = 1'b1;
        step(120);
        ls_seen = 1'b0;
        pwm = 1'b0;
        step(213);
        chk(!ls_seen, "R5 low side stays off on timeout", ls_seen, 0);
        sw_stuck = 1'b0;
        step(30);
        chk(ls === 1'b0, "R5 low side off until next period", ls, 0);
        period(120, 213);
        chk(ls === 1'b1, "R4 low side back after timeout period", ls, 1);

        // Duty cap
        ls_rise_pwm = 1'b0;
        period(400, 200);
        chk(last_hs_run == MAXON, "R6 high-side run capped", last_hs_run, MAXON);
        chk(ls_rise_pwm, "R6 low side on after cap while PWM high", ls_rise_pwm, 1);

        // Shutdown during high phase
        pwm = 1'b1;
        step(60);
        chk(hs === 1'b1, "R7 high side on before shutdown", hs, 1);
        sd = 1'b1;
        step(SYNC);
        chk(hs === 1'b1, "R7 latency before forced off", hs, 1);
        step(1);
        chk(!hs && !ls, "R7 drives forced off", {30'd0, hs, ls}, 0);
        hs_seen = 1'b0;
        ls_seen = 1'b0;
        step(50);
        sd = 1'b0;
        step(20);
        pwm = 1'b0;
        step(20);
        chk(!hs_seen && !ls_seen, "R7 drives off until next PWM rise",
            {30'd0, hs_seen, ls_seen}, 0);
        period(120, 213);
        chk(ls === 1'b1, "R7 switching resumes after release", ls, 1);

        // comp_low during low phase
        cl = 1'b1;
        step(SYNC);
        chk(ls === 1'b1, "R8 latency before forced off", ls, 1);
        step(1);
        chk(!hs && !ls, "R8 drives forced off", {30'd0, hs, ls}, 0);
        step(20);
        cl = 1'b0;
        hs_seen = 1'b0;
        ls_seen = 1'b0;
        step(30);
        chk(!hs_seen && !ls_seen, "R8 drives off after release", {30'd0, hs_seen, ls_seen}, 0);
        period(120, 213);
        chk(ls === 1'b1, "R8 switching resumes after release", ls, 1);

        // Short PWM pulse aborts the gap
        hs_seen = 1'b0;
        period(2, 100);
        chk(!hs_seen, "R10 short pulse gives no high side", hs_seen, 0);
        chk(ls === 1'b1, "R10 low side back after aborted gap", ls, 1);

        period(150, 183);
        step(5);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule